// File: doc/BRIEF.md
# Four-Channel Shared-Counter Pulse-Width Modulator

This block generates four pulse-width modulated outputs from one up-counter. A divider built from a power-of-two prescaler slows the base clock to a counter tick. On each tick the counter steps from zero up to a programmable top value and then returns to zero. Each channel owns a 16-bit compare word. The top bit of the word sets the channel's polarity and the lower fifteen bits hold its compare value. The output level comes from comparing the counter with that value.

Software writes compare words one channel at a time into pending holders. A write alone has no visible effect. A start strobe issued while the block is idle loads every pending word at once and restarts the counter at zero. A start strobe issued while the block runs stages the pending words, and they reach the comparators only when the counter wraps, so no period is ever cut short. A stop strobe, or dropping enable, halts the counter and drives the outputs low. Each channel also has a pin-assignment bit, and a channel without a pin is neither driven nor enabled.

Left alignment uses the polarity bit set with the pulse width as the value. Right alignment uses the polarity bit clear with top minus width as the value.

Top module: `pwm_quad`

## Requirements
- R1: A compare word has the polarity flag in bit 15 and the compare value in bits 14:0. With bit 15 set, a running channel's output is high while counter < value and low otherwise.
- R2: With bit 15 clear, the levels are inverted: high while counter >= value. Writing top minus w with bit 15 clear gives w+1 high cycles at the end of each period (right alignment).
- R3: While running, the counter counts 0,1,…,top and then returns to 0. One period therefore spans (top+1)·2^p clock cycles.
- R4: The counter advances once every 2^p clock cycles, where p is the 3-bit prescale field (0 to 7). Each counter value holds for 2^p cycles.
- R5: A compare value greater than top holds the output at its active level (high with bit 15 set) for the whole period.
- R6: Writing a compare word, without a start strobe, leaves every output unchanged.
- R7: A start strobe while running stages the pending words. They become active only at the counter wrap, so the rest of the current period keeps the old words.
- R8: A start strobe while idle and enabled loads the pending words at once. The counter shows 0 in the cycle after the strobe.
- R9: A stop strobe halts the counter and drives all outputs low from the next cycle. A later start restarts from counter 0.
- R10: While enable is low, all outputs are low and start strobes are ignored.
- R11: A channel whose pin-assignment bit is 0 has its drive-enable low and its output low at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Block enable; low forces the block off |
| prescale_i | input | 3 | Tick divider exponent p |
| top_i | input | 15 | Counter top value |
| cmp_wr_i | input | 1 | Write strobe for a pending compare word |
| cmp_sel_i | input | 2 | Channel selected for the write |
| cmp_data_i | input | 16 | Compare word: bit 15 polarity, bits 14:0 value |
| start_i | input | 1 | Start strobe: load or stage pending words |
| stop_i | input | 1 | Stop strobe |
| pin_map_i | input | 4 | Per-channel pin assigned flag |
| pwm_o | output | 4 | PWM outputs |
| pwm_oe_o | output | 4 | Per-channel drive enable (connected flag) |

## Verification
The bench uses the default four channels, a 15-bit compare field and a 3-bit prescale field. It reprograms top and p at run time: top 9 with p 0 allows cycle-exact checks of the edge positions and of the update boundary, and top 3 with p 2 shows each counter value holding for four cycles. Values above top, a zero value, and both polarities appear in the same run, and high-cycle counts are taken over whole periods.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;
    localparam int NUM_CH  = 4;
    localparam int VAL_W   = 15;
    localparam int PSC_W   = 3;
    localparam int WORD_W  = VAL_W + 1;

    typedef struct packed {
        logic             pol;
        logic [VAL_W-1:0] val;
    } cmp_word_t;

    localparam cmp_word_t WORD_IDLE = '{pol: 1'b1, val: '0};

    function automatic logic chan_level(input cmp_word_t w, input logic [VAL_W-1:0] cnt);
        logic below;
        below = (cnt < w.val);
        return w.pol ? below : ~below;
    endfunction
endpackage

// File: rtl/pwm_quad_prescale.sv
module pwm_quad_prescale #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic [PSC_W-1:0] ps_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit  = ~({DIV_W{1'b1}} << ps_i);
        tick_o = (div_q == limit);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i || tick_o) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (div_q == '0)); // R4
endmodule

// File: rtl/pwm_quad_counter.sv
module pwm_quad_counter #(
    parameter int VAL_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [VAL_W-1:0] top_i,
    output logic [VAL_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [VAL_W-1:0] cnt_q;

    assign cnt_o  = cnt_q;
    assign wrap_o = !clr_i && tick_i && (cnt_q == top_i);

    always_ff @(posedge clk) begin
        if (rst || clr_i)    cnt_q <= '0;
        else if (tick_i) begin
            if (cnt_q == top_i) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0)); // R3
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !tick_i) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/pwm_quad_chbank.sv
module pwm_quad_chbank
    import pwm_quad_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_i,
    input  logic [$clog2(NCH)-1:0] sel_i,
    input  cmp_word_t              data_i,
    input  logic                   load_now_i,
    input  logic                   stage_i,
    input  logic                   flush_i,
    input  logic                   wrap_i,
    output cmp_word_t [NCH-1:0]    active_o
);
    cmp_word_t [NCH-1:0] pend_q;
    cmp_word_t [NCH-1:0] staged_q;
    cmp_word_t [NCH-1:0] active_q;
    logic                stage_v_q;

    assign active_o = active_q;

    for (genvar i = 0; i < NCH; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst)                                       pend_q[i] <= WORD_IDLE;
            else if (wr_i && sel_i == ($clog2(NCH))'(i))   pend_q[i] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q  <= {NCH{WORD_IDLE}};
            active_q  <= {NCH{WORD_IDLE}};
            stage_v_q <= 1'b0;
        end else if (flush_i) begin
            stage_v_q <= 1'b0;
        end else if (load_now_i) begin
            active_q  <= pend_q;
            stage_v_q <= 1'b0;
        end else if (wrap_i) begin
            if (stage_i)        active_q <= pend_q;
            else if (stage_v_q) active_q <= staged_q;
            stage_v_q <= 1'b0;
        end else if (stage_i) begin
            staged_q  <= pend_q;
            stage_v_q <= 1'b1;
        end
    end

    AST_NO_MIDPERIOD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!load_now_i && !wrap_i) |=> $stable(active_q)); // R7
endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int NCH = NUM_CH,
    parameter int VW  = VAL_W,
    parameter int PW  = PSC_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable_i,
    input  logic [PW-1:0]          prescale_i,
    input  logic [VW-1:0]          top_i,
    input  logic                   cmp_wr_i,
    input  logic [$clog2(NCH)-1:0] cmp_sel_i,
    input  logic [VW:0]            cmp_data_i,
    input  logic                   start_i,
    input  logic                   stop_i,
    input  logic [NCH-1:0]         pin_map_i,
    output logic [NCH-1:0]         pwm_o,
    output logic [NCH-1:0]         pwm_oe_o
);
    logic                run_q;
    logic                flush, load_now, stage, tick, wrap;
    logic [VW-1:0]       cnt;
    cmp_word_t [NCH-1:0] active;

    assign flush    = !enable_i || stop_i;
    assign load_now = !flush && start_i && !run_q;
    assign stage    = !flush && start_i && run_q;

    always_ff @(posedge clk) begin
        if (rst || flush) run_q <= 1'b0;
        else if (start_i) run_q <= 1'b1;
    end

    pwm_quad_prescale #(.PSC_W(PW)) u_psc (
        .clk(clk), .rst(rst), .clr_i(!run_q), .ps_i(prescale_i), .tick_o(tick)
    );

    pwm_quad_counter #(.VAL_W(VW)) u_cnt (
        .clk(clk), .rst(rst), .clr_i(!run_q), .tick_i(tick), .top_i(top_i),
        .cnt_o(cnt), .wrap_o(wrap)
    );

    pwm_quad_chbank #(.NCH(NCH)) u_bank (
        .clk(clk), .rst(rst), .wr_i(cmp_wr_i), .sel_i(cmp_sel_i),
        .data_i(cmp_word_t'(cmp_data_i)), .load_now_i(load_now), .stage_i(stage),
        .flush_i(flush), .wrap_i(wrap), .active_o(active)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_out
        assign pwm_oe_o[i] = pin_map_i[i];
        assign pwm_o[i]    = run_q && pin_map_i[i] && chan_level(active[i], cnt);
    end

    AST_STOP_QUIETS: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> (pwm_o == '0)); // R9
    AST_DISABLE_QUIETS: assert property (@(posedge clk) disable iff (rst)
        !enable_i |=> (pwm_o == '0)); // R10
    AST_IDLE_START_ZERO: assert property (@(posedge clk) disable iff (rst)
        (start_i && enable_i && !stop_i && !run_q) |=> (cnt == '0)); // R8
endmodule

// File: tb/pwm_quad_test.sv
module pwm_quad_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable_i = 1'b0;
    logic [2:0]  prescale_i = '0;
    logic [14:0] top_i = 15'd9;
    logic        cmp_wr_i = 1'b0;
    logic [1:0]  cmp_sel_i = '0;
    logic [15:0] cmp_data_i = '0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [3:0]  pin_map_i = 4'hF;
    logic [3:0]  pwm_o, pwm_oe_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pwm_quad uut (
        .clk(clk), .rst(rst), .enable_i(enable_i), .prescale_i(prescale_i),
        .top_i(top_i), .cmp_wr_i(cmp_wr_i), .cmp_sel_i(cmp_sel_i),
        .cmp_data_i(cmp_data_i), .start_i(start_i), .stop_i(stop_i),
        .pin_map_i(pin_map_i), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(int ch, bit pol, int val);
        cmp_wr_i = 1'b1; cmp_sel_i = 2'(ch); cmp_data_i = {pol, 15'(val)};
        step();
        cmp_wr_i = 1'b0;
    endtask

    task automatic pulse_start();
        start_i = 1'b1; step(); start_i = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1; step(); stop_i = 1'b0;
    endtask

    task automatic count_high(int n, output int c[4]);
        for (int k = 0; k < 4; k++) c[k] = 0;
        for (int j = 0; j < n; j++) begin
            for (int k = 0; k < 4; k++) c[k] += int'(pwm_o[k]);
            step();
        end
    endtask

    function automatic int exp_high(bit pol, int val, int top, int p);
        int m;
        m = (val > top + 1) ? top + 1 : val;
        return (pol ? m : top + 1 - m) << p;
    endfunction

    task automatic t_reset();
        check("R9 reset outputs low", int'(pwm_o), 0);
    endtask

    task automatic t_left_mix();
        int c[4];
        pulse_stop(); top_i = 15'd9; prescale_i = 3'd0;
        wr(0, 1, 3); wr(1, 1, 0); wr(2, 0, 5); wr(3, 1, 20);
        pulse_start();
        check("R8 cnt0 ch0 high", int'(pwm_o[0]), 1);
        count_high(10, c);
        check("R1 ch0 left 3", c[0], exp_high(1, 3, 9, 0));
        check("R1 ch1 value 0", c[1], exp_high(1, 0, 9, 0));
        check("R2 ch2 inverted", c[2], exp_high(0, 5, 9, 0));
        check("R5 ch3 above top", c[3], exp_high(1, 20, 9, 0));
        check("R3 wrap ch0 high again", int'(pwm_o[0]), 1);
        wr(0, 1, 7);
        count_high(10, c);
        check("R6 write without start", c[0], 3);
    endtask

    task automatic t_right();
        int c[4];
        pulse_stop(); top_i = 15'd9; prescale_i = 3'd0;
        wr(0, 0, 9 - 2);
        pulse_start();
        for (int j = 0; j < 6; j++) step();
        check("R2 right cnt6 low", int'(pwm_o[0]), 0);
        step();
        check("R2 right cnt7 high", int'(pwm_o[0]), 1);
        step(); step(); step();
        count_high(10, c);
        check("R2 right width", c[0], 3);
    endtask

    task automatic t_prescale();
        int c[4];
        pulse_stop(); top_i = 15'd3; prescale_i = 3'd2;
        wr(0, 1, 2); wr(1, 0, 1);
        pulse_start();
        for (int j = 0; j < 8; j++) begin
            if (j == 7) check("R4 cnt held 4 cycles high", int'(pwm_o[0]), 1);
            step();
        end
        check("R4 low after 8 cycles", int'(pwm_o[0]), 0);
        for (int j = 0; j < 8; j++) step();
        count_high(16, c);
        check("R3 prescaled ch0", c[0], exp_high(1, 2, 3, 2));
        check("R4 prescaled ch1", c[1], exp_high(0, 1, 3, 2));
    endtask

    task automatic t_boundary();
        int c[4];
        int lows = 0;
        pulse_stop(); top_i = 15'd9; prescale_i = 3'd0;
        wr(0, 1, 3);
        pulse_start();
        for (int j = 0; j < 4; j++) step();
        wr(0, 1, 8);
        start_i = 1'b1;
        lows += int'(pwm_o[0]);
        step(); start_i = 1'b0;
        for (int j = 0; j < 4; j++) begin lows += int'(pwm_o[0]); step(); end
        check("R7 old word until wrap", lows, 0);
        count_high(10, c);
        check("R7 new word after wrap", c[0], 8);
    endtask

    task automatic t_stop();
        int c[4];
        pulse_stop(); top_i = 15'd9; prescale_i = 3'd0;
        wr(0, 1, 20); wr(1, 1, 4);
        pulse_start();
        step(); step();
        pulse_stop();
        count_high(12, c);
        check("R9 stopped ch0", c[0], 0);
        pulse_start();
        check("R9 restart cnt0", int'(pwm_o[1]), 1);
        for (int j = 0; j < 4; j++) step();
        check("R9 restart cnt4 low", int'(pwm_o[1]), 0);
    endtask

    task automatic t_disable();
        int c[4];
        enable_i = 1'b0; step();
        pulse_start();
        count_high(12, c);
        check("R10 disabled start ignored", c[0], 0);
        enable_i = 1'b1; pulse_start();
        count_high(10, c);
        check("R10 re-enabled", c[0], 10);
    endtask

    task automatic t_disconnect();
        int c[4];
        pin_map_i = 4'b1011;
        pulse_stop(); top_i = 15'd9; prescale_i = 3'd0;
        wr(2, 1, 20);
        pulse_start();
        check("R11 oe low", int'(pwm_oe_o[2]), 0);
        count_high(10, c);
        check("R11 unassigned not driven", c[2], 0);
        check("R11 neighbour still drives", c[0], 10);
        pin_map_i = 4'hF;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 1'b0;
        step();
        t_reset();
        enable_i = 1'b1;
        step();
        t_left_mix();
        t_right();
        t_prescale();
        t_boundary();
        t_stop();
        t_disable();
        t_disconnect();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule